// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block walks a circular list of transmit buffer descriptors held in system memory and turns each one that software has marked ready into a transfer command for a separate data mover. Software places descriptors in memory, sets their ready flags, and then pulses a doorbell. The walker fetches descriptors one by one through a request/acknowledge memory port. For each ready entry it issues a command carrying the buffer address, the byte count, an end-of-frame flag and an append-CRC flag. When the data mover reports that the buffer has been consumed, the walker rewrites the descriptor's control word with the ready flag cleared. This returns ownership of the buffer to software.

Each descriptor takes eight bytes. The control word sits at the descriptor address and the buffer address sits four bytes above it. An empty descriptor is read a second time before the walker stops. A doorbell that arrives while the walker is running is remembered, so the walker keeps polling instead of stopping. A flag in the control word marks the last entry of the ring, and the walker then returns to the ring base. The ring base is a register. Writing it, or resetting the block, moves the current position to that base.

Top module: `txd_ring_walker`

## Requirements
- R1: After reset the walker is idle (`busy`=0), issues no memory request and no command, and the ring base and current position are `RST_BASE`.
- R2: A `bell_wr` pulse while idle makes the walker request a read of the control word at the current position on the cycle after the pulse, with `busy` high.
- R3: Descriptors are handled strictly in ring order. For a control word with bit 31 (ready) set, the walker reads the buffer-address word at position+4 and then issues exactly one command.
- R4: The command carries the address from the second word and the length from control bits 15:0. `cmd_last` equals control bit 27.
- R5: `cmd_crc` equals control bit 26 when bit 27 is set, and is 0 on any command whose bit 27 is clear.
- R6: Only after `mov_done` does the walker write the control word back to the same address, with bit 31 cleared and every other bit unchanged.
- R7: When a control word reads with bit 31 clear, the walker reads the same address once more. If bit 31 is still clear and no doorbell is pending, it goes idle after exactly two reads.
- R8: After a write-back, the next descriptor is at the ring base if control bit 29 (wrap) was set, and at position+8 otherwise.
- R9: A `bell_wr` pulse while busy is held pending. After two empty reads it is consumed and the same descriptor is polled twice more before going idle.
- R10: A `base_wr` pulse stores `base_in`, with its low three bits forced to zero, as the ring base and sets the current position to it.
- R11: An outstanding memory request keeps its address, direction and data until `mem_ack`. An offered command stays valid and unchanged until `cmd_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_wr | input | 1 | Ring base write strobe |
| base_in | input | AW | New ring base address |
| bell_wr | input | 1 | Doorbell write strobe |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory word address (byte address) |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access accepted this cycle; read data valid |
| mem_rdata | input | 32 | Read data |
| cmd_valid | output | 1 | Transfer command offered |
| cmd_ready | input | 1 | Data mover accepts the command |
| cmd_addr | output | 32 | Buffer address |
| cmd_len | output | 16 | Buffer byte count |
| cmd_last | output | 1 | Buffer ends a frame |
| cmd_crc | output | 1 | Transmitter appends CRC to this frame |
| mov_done | input | 1 | Data mover finished the current buffer |
| busy | output | 1 | Walker is active |

## Verification
Reset synchronization adds two cycles of latency after `rst_n` rises. After that, the only fixed latency is from doorbell to first request: the read of the control word is due on the cycle after the `bell_wr` pulse, and the bench samples it at the following falling edge. The other results depend on handshakes whose timing the bench deliberately varies. Memory acknowledges one cycle after a request, `cmd_ready` toggles, and `mov_done` comes four cycles after acceptance. For those results the bench logs every completed memory access and accepted command at the clock edge, and compares the logs in order against sequences it works out from the descriptor contents once `busy` falls. Hold violations on both handshakes are counted cycle by cycle.

// File: rtl/txd_pkg.sv
`timescale 1ns/1ps
package txd_pkg;
  localparam int CTL_RDY_BIT  = 31;
  localparam int CTL_WRAP_BIT = 29;
  localparam int CTL_LAST_BIT = 27;
  localparam int CTL_CRC_BIT  = 26;
  localparam int LEN_W        = 16;
  localparam int WORD_W       = 32;
  localparam int DESC_BYTES   = 8;
  localparam int ADDR_OFS     = 4;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CTL  = 3'd1,
    ST_BUF  = 3'd2,
    ST_CMD  = 3'd3,
    ST_WAIT = 3'd4,
    ST_WB   = 3'd5
  } walk_state_e;
endpackage

// File: rtl/txd_ring_ptr.sv
`timescale 1ns/1ps
module txd_ring_ptr
  import txd_pkg::*;
#(
  parameter int          AW       = 32,
  parameter logic [AW-1:0] RST_BASE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_wr,
  input  logic [AW-1:0] base_in,
  input  logic          step,
  input  logic          wrap,
  output logic [AW-1:0] cur_ptr
);
  localparam int            ALIGN    = $clog2(DESC_BYTES);
  localparam logic [AW-1:0] LOW_MASK = AW'((1 << ALIGN) - 1);
  localparam logic [AW-1:0] STRIDE   = AW'(DESC_BYTES);

  logic [AW-1:0] base_q, base_d;
  logic [AW-1:0] cur_q, cur_d;
  logic [AW-1:0] base_aligned;
  logic          base_en, cur_en;

  always_comb begin
    base_aligned = base_in & ~LOW_MASK;
    base_en      = base_wr;
    base_d       = base_aligned;
    cur_en       = base_wr | step;
    if (base_wr)   cur_d = base_aligned;
    else if (wrap) cur_d = base_q;
    else           cur_d = cur_q + STRIDE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= RST_BASE & ~LOW_MASK;
      cur_q  <= RST_BASE & ~LOW_MASK;
    end else begin
      if (base_en) base_q <= base_d;
      if (cur_en)  cur_q  <= cur_d;
    end
  end

  assign cur_ptr = cur_q;

  // R10: a base write lands the current position on the aligned base
  a_r10_base_sets_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |=> (cur_ptr == $past(base_in & ~LOW_MASK)));
endmodule

// File: rtl/txd_seq.sv
`timescale 1ns/1ps
module txd_seq
  import txd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bell,
  input  logic [AW-1:0]     cur_ptr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [WORD_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_len,
  output logic              cmd_last,
  output logic              cmd_crc,
  input  logic              mov_done,
  output logic              step,
  output logic              wrap,
  output logic              busy
);
  localparam logic [WORD_W-1:0] RDY_MASK = WORD_W'(1) << CTL_RDY_BIT;

  walk_state_e       state_q, state_d;
  logic              polled_q, polled_d;
  logic              pend_q, pend_d;
  logic [WORD_W-1:0] ctl_q, buf_q;
  logic              ctl_en, buf_en;
  logic              hs;

  assign hs = mem_req & mem_ack;

  always_comb begin
    state_d  = state_q;
    polled_d = polled_q;
    pend_d   = pend_q;
    ctl_en   = 1'b0;
    buf_en   = 1'b0;
    step     = 1'b0;
    if (bell && state_q != ST_IDLE) pend_d = 1'b1;
    unique case (state_q)
      ST_IDLE: begin
        if (bell) begin
          state_d  = ST_CTL;
          polled_d = 1'b0;
          pend_d   = 1'b0;
        end
      end
      ST_CTL: begin
        if (hs) begin
          if (mem_rdata[CTL_RDY_BIT]) begin
            ctl_en   = 1'b1;
            polled_d = 1'b0;
            state_d  = ST_BUF;
          end else if (!polled_q) begin
            polled_d = 1'b1;
          end else if (pend_q || bell) begin
            pend_d   = 1'b0;
            polled_d = 1'b0;
          end else begin
            state_d  = ST_IDLE;
          end
        end
      end
      ST_BUF: begin
        if (hs) begin
          buf_en  = 1'b1;
          state_d = ST_CMD;
        end
      end
      ST_CMD:  if (cmd_ready) state_d = ST_WAIT;
      ST_WAIT: if (mov_done)  state_d = ST_WB;
      ST_WB: begin
        if (hs) begin
          step     = 1'b1;
          polled_d = 1'b0;
          state_d  = ST_CTL;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      polled_q <= 1'b0;
      pend_q   <= 1'b0;
      ctl_q    <= '0;
      buf_q    <= '0;
    end else begin
      state_q  <= state_d;
      polled_q <= polled_d;
      pend_q   <= pend_d;
      if (ctl_en) ctl_q <= mem_rdata;
      if (buf_en) buf_q <= mem_rdata;
    end
  end

  always_comb begin
    mem_req   = (state_q == ST_CTL) || (state_q == ST_BUF) || (state_q == ST_WB);
    mem_we    = (state_q == ST_WB);
    mem_addr  = (state_q == ST_BUF) ? cur_ptr + AW'(ADDR_OFS) : cur_ptr;
    mem_wdata = ctl_q & ~RDY_MASK;
    cmd_valid = (state_q == ST_CMD);
    cmd_addr  = buf_q;
    cmd_len   = ctl_q[LEN_W-1:0];
    cmd_last  = ctl_q[CTL_LAST_BIT];
    cmd_crc   = ctl_q[CTL_CRC_BIT] & ctl_q[CTL_LAST_BIT];
    wrap      = ctl_q[CTL_WRAP_BIT];
    busy      = (state_q != ST_IDLE);
  end

  // Independent trackers for the checks below
  logic       done_seen_q;
  logic [1:0] cmd_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_seen_q <= 1'b0;
      cmd_cnt_q   <= '0;
    end else begin
      if (mov_done) done_seen_q <= 1'b1;
      else if (hs && mem_we) done_seen_q <= 1'b0;
      if (hs && !mem_we && mem_rdata[CTL_RDY_BIT] && state_q == ST_CTL) cmd_cnt_q <= '0;
      else if (cmd_valid && cmd_ready && cmd_cnt_q != 2'd3) cmd_cnt_q <= cmd_cnt_q + 2'd1;
    end
  end

  // R11: memory request held steady until acknowledged
  a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R11: command held steady until accepted
  a_r11_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_len)
                                   && $stable(cmd_last) && $stable(cmd_crc)));

  // R6: no write-back before the data mover has finished
  a_r6_wb_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> done_seen_q);

  // R3: at most one command per ready descriptor
  a_r3_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |-> (cmd_cnt_q == 2'd0));

  // R6: the write-back never hands a buffer back as ready
  a_r6_wb_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[CTL_RDY_BIT]);
endmodule

// File: rtl/txd_ring_walker.sv
`timescale 1ns/1ps
module txd_ring_walker
  import txd_pkg::*;
#(
  parameter int            AW       = 32,
  parameter logic [AW-1:0] RST_BASE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_wr,
  input  logic [AW-1:0] base_in,
  input  logic          bell_wr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [31:0]   cmd_addr,
  output logic [15:0]   cmd_len,
  output logic          cmd_last,
  output logic          cmd_crc,
  input  logic          mov_done,
  output logic          busy
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic [AW-1:0] cur_ptr;
  logic          step, wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  txd_ring_ptr #(.AW(AW), .RST_BASE(RST_BASE)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .base_wr (base_wr),
    .base_in (base_in),
    .step    (step),
    .wrap    (wrap),
    .cur_ptr (cur_ptr)
  );

  txd_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bell      (bell_wr),
    .cur_ptr   (cur_ptr),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_addr  (cmd_addr),
    .cmd_len   (cmd_len),
    .cmd_last  (cmd_last),
    .cmd_crc   (cmd_crc),
    .mov_done  (mov_done),
    .step      (step),
    .wrap      (wrap),
    .busy      (busy)
  );

  // R2: a doorbell from idle raises a control-word read on the next cycle
  a_r2_bell_start: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bell_wr && !busy) |=> (mem_req && !mem_we && busy));
endmodule

// File: tb/test_txd_ring_walker.sv
`timescale 1ns/1ps
module test_txd_ring_walker;
  localparam int AW = 32;
  localparam logic [31:0] RDY = 32'h8000_0000, WRP = 32'h2000_0000,
                          LST = 32'h0800_0000, CRC = 32'h0400_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic base_wr = 1'b0, bell_wr = 1'b0;
  logic [AW-1:0] base_in = '0;
  logic mem_req, mem_we, mem_ack, cmd_valid, cmd_ready, cmd_last, cmd_crc, mov_done, busy;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata, cmd_addr;
  logic [15:0] cmd_len;

  always #10 clk = ~clk;

  txd_ring_walker #(.AW(AW)) i_txd_ring_walker (
    .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_in(base_in), .bell_wr(bell_wr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_last(cmd_last), .cmd_crc(cmd_crc),
    .mov_done(mov_done), .busy(busy));

  int n_cmp = 0, n_bad = 0;
  logic [31:0] mem [64];
  logic [31:0] lg_addr [128];
  logic [31:0] lg_dat  [128];
  logic        lg_we   [128];
  int          lg_n = 0;
  logic [31:0] c_addr [32];
  logic [15:0] c_len  [32];
  logic        c_last [32];
  logic        c_crc  [32];
  int          c_n = 0;
  int          dly = 0;
  int          viol = 0;
  logic        rq_wait = 1'b0, cq_wait = 1'b0;
  logic [31:0] hold_a = '0;

  // memory model, data mover model, handshake monitors
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_rdata <= '0; cmd_ready <= 1'b0; mov_done <= 1'b0; dly <= 0;
    end else begin
      mem_ack   <= mem_req && !mem_ack;
      mem_rdata <= mem[mem_addr[7:2]];
      if (mem_req && mem_ack) begin
        lg_addr[lg_n] <= mem_addr; lg_we[lg_n] <= mem_we; lg_dat[lg_n] <= mem_wdata;
        lg_n <= lg_n + 1;
        if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
      end
      cmd_ready <= ~cmd_ready;
      if (cmd_valid && cmd_ready) begin
        c_addr[c_n] <= cmd_addr; c_len[c_n] <= cmd_len;
        c_last[c_n] <= cmd_last; c_crc[c_n] <= cmd_crc;
        c_n <= c_n + 1; dly <= 4;
      end else if (dly != 0) dly <= dly - 1;
      mov_done <= (dly == 1);
      if (rq_wait && (!mem_req || mem_addr != hold_a)) viol <= viol + 1;
      if (cq_wait && !cmd_valid) viol <= viol + 1;
      rq_wait <= mem_req && !mem_ack;
      cq_wait <= cmd_valid && !cmd_ready;
      hold_a  <= mem_addr;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  int k = 0, ck = 0;
  task automatic exp_rd(input string tag, input logic [31:0] a);
    chk({tag, " read addr"}, lg_addr[k], a);
    chk({tag, " read dir"}, 32'(lg_we[k]), 32'd0);
    k++;
  endtask
  task automatic exp_wr(input string tag, input logic [31:0] a, input logic [31:0] d);
    chk({tag, " wb addr"}, lg_addr[k], a);
    chk({tag, " wb dir"}, 32'(lg_we[k]), 32'd1);
    chk({tag, " wb data"}, lg_dat[k], d);
    k++;
  endtask
  task automatic exp_cmd(input string tag, input logic [31:0] a, input logic [15:0] l,
                         input logic last, input logic crc);
    chk({tag, " cmd addr"}, c_addr[ck], a);
    chk({tag, " cmd len"}, 32'(c_len[ck]), 32'(l));
    chk({tag, " cmd last"}, 32'(c_last[ck]), 32'(last));
    chk({tag, " cmd crc"}, 32'(c_crc[ck]), 32'(crc));
    ck++;
  endtask
  // process one ready descriptor at address a with control word w, buffer address b
  task automatic exp_desc(input string tag, input logic [31:0] a, input logic [31:0] w,
                          input logic [31:0] b);
    exp_rd(tag, a); exp_rd(tag, a + 4); exp_wr(tag, a, w & ~RDY);
    exp_cmd(tag, b, w[15:0], w[27], w[26] & w[27]);
  endtask

  task automatic ring;
    @(negedge clk); bell_wr = 1'b1;
    @(negedge clk); bell_wr = 1'b0;
  endtask
  task automatic wait_idle;
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask
  task automatic put(input logic [31:0] a, input logic [31:0] w, input logic [31:0] b);
    mem[a[7:2]] = w; mem[a[7:2] + 1] = b;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: got hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 cmd_valid", 32'(cmd_valid), 0);
    chk("R1 position", mem_addr, 32'h0);

    // R10: move the ring to 0x40 (low bits of base_in dropped)
    base_in = 32'h45; base_wr = 1'b1; @(negedge clk); base_wr = 1'b0;
    put(32'h40, RDY | CRC | 32'd100, 32'h1000);
    put(32'h48, RDY | LST | CRC | 32'd60, 32'h2000);
    put(32'h50, RDY | LST | 32'd20, 32'h3000);
    put(32'h58, WRP, 32'h4000);
    // R2: doorbell, request on the next cycle at the current position
    @(negedge clk); bell_wr = 1'b1;
    @(negedge clk); bell_wr = 1'b0;
    chk("R2 req after bell", 32'(mem_req), 1);
    chk("R2 busy after bell", 32'(busy), 1);
    chk("R10 first addr", mem_addr, 32'h40);
    chk("R2 read dir", 32'(mem_we), 0);
    wait_idle;
    // R3 R4 R5 R6: three ready descriptors in order; R7: double poll then idle
    exp_desc("R5 no crc without last", 32'h40, RDY | CRC | 32'd100, 32'h1000);
    exp_desc("R4 last with crc", 32'h48, RDY | LST | CRC | 32'd60, 32'h2000);
    exp_desc("R3 order third", 32'h50, RDY | LST | 32'd20, 32'h3000);
    exp_rd("R7 first poll", 32'h58);
    exp_rd("R7 second poll", 32'h58);
    chk("R7 read count", 32'(lg_n), 32'(k));
    chk("R3 cmd count", 32'(c_n), 32'(ck));
    chk("R7 idle", 32'(busy), 0);

    // R8: wrap entry then back to base
    put(32'h58, RDY | WRP | LST | CRC | 32'd8, 32'h5000);
    put(32'h40, RDY | LST | 32'd16, 32'h6000);
    ring; wait_idle;
    exp_desc("R8 wrap entry", 32'h58, RDY | WRP | LST | CRC | 32'd8, 32'h5000);
    exp_desc("R8 back at base", 32'h40, RDY | LST | 32'd16, 32'h6000);
    exp_rd("R7 poll a", 32'h48);
    exp_rd("R7 poll b", 32'h48);
    chk("R8 read count", 32'(lg_n), 32'(k));

    // R9: doorbell while busy is held and causes two more polls
    put(32'h48, RDY | LST | 32'd32, 32'h7000);
    begin
      int c0;
      c0 = c_n;
      ring;
      while (c_n == c0) @(negedge clk);
      chk("R9 busy at mid bell", 32'(busy), 1);
      ring;
    end
    wait_idle;
    exp_desc("R9 descriptor", 32'h48, RDY | LST | 32'd32, 32'h7000);
    for (int p = 0; p < 4; p++) exp_rd("R9 poll", 32'h50);
    chk("R9 read count", 32'(lg_n), 32'(k));
    chk("R9 idle", 32'(busy), 0);

    // R10: new base, a one-entry ring that wraps to itself
    base_in = 32'h80; base_wr = 1'b1; @(negedge clk); base_wr = 1'b0;
    put(32'h80, RDY | WRP | LST | 32'd4, 32'h8000);
    ring; wait_idle;
    exp_desc("R10 new base", 32'h80, RDY | WRP | LST | 32'd4, 32'h8000);
    exp_rd("R8 self wrap a", 32'h80);
    exp_rd("R8 self wrap b", 32'h80);
    chk("R10 read count", 32'(lg_n), 32'(k));
    chk("R6 memory after wb", mem[32'h80 >> 2], WRP | LST | 32'd4);

    // R11: no request or command dropped before its handshake
    chk("R11 hold violations", 32'(viol), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule